// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

The block is a free-running watchdog counter clocked by the system clock. A 2-bit mode field picks one of four interval lengths. When the counter reaches the end of the chosen interval, the block sets a warning flag. A fixed gap later it sets a time-out flag. If software has enabled it, the block also issues a one-cycle system reset request at that moment. The counter then wraps to zero and keeps running. Software holds the reset off by restarting the counter before the interval ends.

Software reaches the block through a small write port and a read-back bus. Address 0 holds the control and status register. Address 1 is a key port. The restart bit and the reset-enable bit change only inside a short window that opens after the correct two-key unlock sequence. The flags are sticky. Software clears them by writing 0. The warning flag can drive an interrupt output, which makes the block usable as a time base.

The parameter `SCALE_SHIFT` (0 to 9) divides every interval and the gap by 2^SCALE_SHIFT, so short simulations can reach every mode. In the formulas below, S stands for `SCALE_SHIFT`.

Top module: `wdog_timer`

## Requirements
- R1: The control register is read on `ctrl_o` with this layout: bit0 restart (always reads 0), bit1 reset enable, bit2 interrupt enable, bit3 warning flag, bit4 time-out flag, bits6:5 mode, bit7 reads 0. After reset `ctrl_o`, `irq_o` and `rst_req_o` are all 0. A write to address 0 always updates the mode and interrupt-enable bits.
- R2: With mode m (00..11), the warning flag is set on the 2^(17+3m-S)-th clock edge after the counter was last cleared.
- R3: The time-out flag is set 2^(9-S) clock edges after the warning flag is set. On that edge the counter wraps to zero and starts a new interval.
- R4: The counter runs from reset with no enable bit. Both flags are set on schedule whatever the state of the enable bits.
- R5: `irq_o` is high exactly while the warning flag and the interrupt-enable bit are both 1.
- R6: `rst_req_o` is a one-cycle pulse in the cycle the time-out flag becomes set. It occurs only if the reset-enable bit held 1 before that edge.
- R7: An accepted restart clears the counter and starts a full interval under the mode in force. It does not clear either flag. If it lands on the edge where a flag would be set, that flag is not set.
- R8: The unlock is a write of 0xAA to address 1 followed, as the next write, by 0x55 to address 1. An address-0 write made in any of the 4 clock edges after the 0x55 edge is accepted as protected. Any address-0 write ends the window.
- R9: On an address-0 write outside the window, the restart bit is ignored and the reset-enable bit keeps its value. Any write other than the expected next key cancels a pending unlock.
- R10: The flags are sticky. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. If a clear lands on the same edge as a set, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, also the counter's time base |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_addr_i | input | 1 | 0 = control register, 1 = key port |
| wr_data_i | input | 8 | Write data |
| ctrl_o | output | 8 | Control and status read-back |
| irq_o | output | 1 | Gated warning interrupt (level) |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Two pairs of events can fall on the same edge, and the bench provokes both. First, a software clear of the warning flag is timed to land on the edge where the counter sets that flag. The flag must read 1 afterwards, and a clear one edge later must take effect. Second, an unlocked restart is timed to land on the exact time-out edge. The time-out flag must stay 0, and a full interval must follow from that edge. A cycle-by-cycle model in the bench judges both cases, and directed checks judge them again.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned MODE_W     = 2;
  localparam int unsigned N_MODES    = 4;
  localparam int unsigned BASE_EXP   = 17;  // mode 0 interval exponent
  localparam int unsigned STEP_EXP   = 3;   // exponent step per mode
  localparam int unsigned GAP_EXP    = 9;   // warning-to-timeout gap exponent
  localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_SECOND = 8'h55;

  localparam int unsigned B_RESTART = 0;
  localparam int unsigned B_RST_EN  = 1;
  localparam int unsigned B_INT_EN  = 2;
  localparam int unsigned B_WARN    = 3;
  localparam int unsigned B_TOUT    = 4;
  localparam int unsigned B_MODE    = 5;

  typedef enum logic {
    ADDR_CTRL = 1'b0,
    ADDR_KEY  = 1'b1
  } wdt_addr_e;

  typedef logic [MODE_W-1:0] wdt_mode_t;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_pkg::*;
#(
  parameter int unsigned WIN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              prot_ok_o
);
  localparam int unsigned WIN_W = $clog2(WIN + 1);

  logic             got_first_q;
  logic [WIN_W-1:0] win_q;
  logic             wr_key, wr_ctrl;

  assign wr_key    = wr_en_i && (wr_addr_i == ADDR_KEY);
  assign wr_ctrl   = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign prot_ok_o = (win_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      got_first_q <= 1'b0;
      win_q       <= '0;
    end else if (wr_key) begin
      if (wr_data_i == KEY_FIRST) begin
        got_first_q <= 1'b1;
        win_q       <= '0;
      end else if (got_first_q && wr_data_i == KEY_SECOND) begin
        got_first_q <= 1'b0;
        win_q       <= WIN_W'(WIN);
      end else begin
        got_first_q <= 1'b0;
        win_q       <= '0;
      end
    end else if (wr_ctrl) begin
      // any control write consumes or cancels the unlock
      got_first_q <= 1'b0;
      win_q       <= '0;
    end else if (win_q != '0) begin
      win_q <= win_q - 1'b1;
    end
  end

  AST_WIN_FROM_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prot_ok_o) |-> $past(wr_key && wr_data_i == KEY_SECOND)); // R8
  AST_WIN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q <= WIN_W'(WIN)); // R8
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned SCALE_SHIFT = 0,
  parameter int unsigned CNT_W       = BASE_EXP + STEP_EXP * (N_MODES - 1) + 1 - SCALE_SHIFT
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  wdt_mode_t mode_i,
  input  logic      restart_i,
  input  logic      rst_en_i,
  output logic      warn_evt_o,
  output logic      tout_evt_o,
  output logic      rst_req_o
);
  localparam logic [CNT_W-1:0] GAP = CNT_W'(64'd1 << (GAP_EXP - SCALE_SHIFT));

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] warn_last_tbl [N_MODES];
  logic [CNT_W-1:0] warn_last, tout_last;
  logic             rst_req_q;

  for (genvar m = 0; m < N_MODES; m++) begin : g_lim
    localparam int unsigned EXP = BASE_EXP + STEP_EXP * m - SCALE_SHIFT;
    assign warn_last_tbl[m] = CNT_W'((64'd1 << EXP) - 64'd1);
  end

  always_comb begin
    warn_last  = warn_last_tbl[mode_i];
    tout_last  = warn_last + GAP;
    warn_evt_o = !restart_i && (cnt_q == warn_last);
    // >= keeps a shortened mode from running the full counter range
    tout_evt_o = !restart_i && (cnt_q >= tout_last);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= tout_evt_o && rst_en_i;
      if (restart_i || tout_evt_o) cnt_q <= '0;
      else                         cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rst_req_o = rst_req_q;

  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0)); // R7
  AST_RST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R6
  AST_EVT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tout_evt_o |-> !warn_evt_o); // R3
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        wr_addr_i,
  input  logic [6:0]  wr_data_i,
  input  logic        prot_ok_i,
  input  logic        warn_evt_i,
  input  logic        tout_evt_i,
  output wdt_mode_t   mode_o,
  output logic        rst_en_o,
  output logic        restart_o,
  output logic        irq_o,
  output logic [DATA_W-1:0] ctrl_o
);
  logic      wr_ctrl;
  wdt_mode_t mode_q;
  logic      int_en_q, rst_en_q, warn_q, tout_q;
  logic      clr_warn, clr_tout;

  assign wr_ctrl   = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign restart_o = wr_ctrl && wr_data_i[B_RESTART] && prot_ok_i;
  assign clr_warn  = wr_ctrl && !wr_data_i[B_WARN];
  assign clr_tout  = wr_ctrl && !wr_data_i[B_TOUT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      int_en_q <= 1'b0;
      rst_en_q <= 1'b0;
    end else if (wr_ctrl) begin
      mode_q   <= wr_data_i[B_MODE +: MODE_W];
      int_en_q <= wr_data_i[B_INT_EN];
      if (prot_ok_i) rst_en_q <= wr_data_i[B_RST_EN];
    end
  end

  // hardware set wins over a same-edge software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warn_q <= 1'b0;
      tout_q <= 1'b0;
    end else begin
      warn_q <= warn_evt_i || (warn_q && !clr_warn);
      tout_q <= tout_evt_i || (tout_q && !clr_tout);
    end
  end

  assign mode_o   = mode_q;
  assign rst_en_o = rst_en_q;
  assign irq_o    = warn_q && int_en_q;
  assign ctrl_o   = {1'b0, mode_q, tout_q, warn_q, int_en_q, rst_en_q, 1'b0};

  AST_WARN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(warn_q) |-> $past(clr_warn)); // R10
  AST_TOUT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tout_q) |-> $past(clr_tout)); // R10
  AST_RST_EN_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rst_en_q) |-> $past(prot_ok_i && wr_ctrl)); // R9
  AST_TOUT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tout_evt_i |=> tout_q); // R3
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdt_pkg::*;
#(
  parameter int unsigned SCALE_SHIFT = 0,
  parameter int unsigned UNLOCK_WIN  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] ctrl_o,
  output logic       irq_o,
  output logic       rst_req_o
);
  wdt_mode_t mode;
  logic      prot_ok, restart, rst_en, warn_evt, tout_evt;

  wdt_unlock #(.WIN(UNLOCK_WIN)) u_unlock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .prot_ok_o (prot_ok)
  );

  wdt_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i[6:0]),
    .prot_ok_i  (prot_ok),
    .warn_evt_i (warn_evt),
    .tout_evt_i (tout_evt),
    .mode_o     (mode),
    .rst_en_o   (rst_en),
    .restart_o  (restart),
    .irq_o      (irq_o),
    .ctrl_o     (ctrl_o)
  );

  wdt_counter #(.SCALE_SHIFT(SCALE_SHIFT)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .restart_i  (restart),
    .rst_en_i   (rst_en),
    .warn_evt_o (warn_evt),
    .tout_evt_o (tout_evt),
    .rst_req_o  (rst_req_o)
  );

  AST_RST_WITH_TOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> ctrl_o[B_TOUT]); // R6
endmodule

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  localparam int SHIFT = 9;
  localparam int GAP   = 1 << (9 - SHIFT);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] ctrl;
  logic       irq, rst_req;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdog_timer #(.SCALE_SHIFT(SHIFT), .UNLOCK_WIN(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ctrl_o(ctrl), .irq_o(irq), .rst_req_o(rst_req)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_cnt, m_mode, m_ie, m_re, m_wf, m_tf, m_got, m_win, m_rq;

  function automatic int interval(input int md);
    return 1 << (17 + 3 * md - SHIFT);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_mode = 0; m_ie = 0; m_re = 0; m_wf = 0; m_tf = 0;
      m_got = 0; m_win = 0; m_rq = 0;
    end else begin
      automatic bit wc = wr_en && !wr_addr;
      automatic bit wk = wr_en && wr_addr;
      automatic bit prot = (m_win > 0);
      automatic bit rs = wc && wr_data[0] && prot;
      automatic int wl = interval(m_mode) - 1;
      automatic bit we = !rs && (m_cnt == wl);
      automatic bit te = !rs && (m_cnt >= wl + GAP);
      m_rq  = te && (m_re != 0);
      m_cnt = (rs || te) ? 0 : m_cnt + 1;
      m_wf  = (we || (m_wf != 0 && !(wc && !wr_data[3]))) ? 1 : 0;
      m_tf  = (te || (m_tf != 0 && !(wc && !wr_data[4]))) ? 1 : 0;
      if (wc) begin
        m_mode = int'(wr_data[6:5]);
        m_ie   = int'(wr_data[2]);
        if (prot) m_re = int'(wr_data[1]);
      end
      if (wk) begin
        if (wr_data == 8'hAA) begin m_got = 1; m_win = 0; end
        else if (m_got != 0 && wr_data == 8'h55) begin m_got = 0; m_win = 4; end
        else begin m_got = 0; m_win = 0; end
      end else if (wc) begin
        m_got = 0; m_win = 0;
      end else if (m_win > 0) begin
        m_win = m_win - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 mode/int_en", {ctrl[6:5], ctrl[2]}, {m_mode[1:0], m_ie[0]});
      chk("R8 R9 rst_en", ctrl[1], m_re);
      chk("R2 warn flag", ctrl[3], m_wf);
      chk("R3 tout flag", ctrl[4], m_tf);
      chk("R5 irq", irq, m_wf & m_ie);
      chk("R6 rst_req", rst_req, m_rq);
    end
  end

  // ---------------- stimulus helpers (called at a negedge) ----------------
  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 1'b0; wr_data = 8'h00;
  endtask

  task automatic unlock();
    wr(1'b1, 8'hAA);
    wr(1'b1, 8'h55);
  endtask

  function automatic logic [7:0] cw(input int md, input bit ie, input bit re,
                                    input bit rs, input bit fw, input bit ft);
    return {1'b0, 2'(md), ft, fw, ie, re, rs};
  endfunction

  task automatic wait_bit(input int b, input int max, output int n);
    n = 0;
    for (int i = 1; i <= max; i++) begin
      @(negedge clk);
      if (ctrl[b]) begin n = i; break; end
    end
  endtask

  int n;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ctrl", ctrl, 0);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset rst_req", rst_req, 0);
    rst_n = 1'b1;

    // R4 R2: free running from reset, mode 0, no enables
    wait_bit(3, 400, n);
    chk("R2 R4 mode0 warn edge", n, 256);
    chk("R5 irq gated off", irq, 0);
    @(negedge clk);
    chk("R3 tout after gap", ctrl[4], 1);
    chk("R6 no pulse when disabled", rst_req, 0);

    // R10: writing 1 keeps flags, writing 0 clears one
    wr(1'b0, cw(0, 0, 0, 0, 1, 1));
    chk("R10 write 1 keeps", ctrl[4:3], 2'b11);
    wr(1'b0, cw(0, 0, 0, 0, 0, 1));
    chk("R10 write 0 clears warn", ctrl[4:3], 2'b10);

    // R9: unprotected restart / rst_en
    wr(1'b0, cw(0, 0, 1, 1, 1, 1));
    chk("R9 rst_en unchanged", ctrl[1], 0);
    // cancelled sequence: control write between keys
    wr(1'b1, 8'hAA);
    wr(1'b0, cw(0, 0, 0, 0, 1, 1));
    wr(1'b1, 8'h55);
    wr(1'b0, cw(0, 0, 1, 0, 1, 1));
    chk("R9 cancelled unlock", ctrl[1], 0);
    // wrong intervening key write
    wr(1'b1, 8'hAA);
    wr(1'b1, 8'h12);
    wr(1'b1, 8'h55);
    wr(1'b0, cw(0, 0, 1, 0, 1, 1));
    chk("R9 wrong key", ctrl[1], 0);

    // R8: window edge 5 rejected, edge 4 accepted
    unlock();
    repeat (4) @(negedge clk);
    wr(1'b0, cw(0, 0, 1, 0, 1, 1));
    chk("R8 late write rejected", ctrl[1], 0);
    unlock();
    repeat (3) @(negedge clk);
    wr(1'b0, cw(0, 0, 1, 0, 1, 1));
    chk("R8 last window edge accepted", ctrl[1], 1);

    // R7 R6: restart with rst_en, clear flags, mode 0
    unlock();
    wr(1'b0, cw(0, 1, 1, 1, 0, 0));
    wait_bit(4, 400, n);
    chk("R7 R3 tout after restart", n, 256 + GAP);
    chk("R6 pulse with tout", rst_req, 1);
    chk("R5 irq with enable", irq, 1);
    @(negedge clk);
    chk("R6 pulse one cycle", rst_req, 0);

    // R7: restart keeps flags
    unlock();
    wr(1'b0, cw(0, 1, 1, 1, 1, 1));
    chk("R7 restart keeps flags", ctrl[4:3], 2'b11);

    // R10 collision: clear lands on the warn-set edge
    unlock();
    wr(1'b0, cw(0, 1, 0, 1, 0, 0));
    chk("R7 restart write clears flags", ctrl[4:3], 2'b00);
    repeat (255) @(negedge clk);
    wr(1'b0, cw(0, 1, 0, 0, 0, 1));
    chk("R10 set wins over clear", ctrl[3], 1);
    wr(1'b0, cw(0, 1, 0, 0, 0, 1));
    chk("R10 later clear works", ctrl[3], 0);
    chk("R5 irq drops", irq, 0);

    // R7 collision: restart lands on timeout edge
    unlock();
    wr(1'b0, cw(0, 0, 0, 1, 0, 0));
    repeat (254) @(negedge clk);
    unlock();
    wr(1'b0, cw(0, 0, 0, 1, 1, 1));
    chk("R7 restart beats timeout", ctrl[4], 0);
    chk("R2 warn was set before", ctrl[3], 1);
    wait_bit(4, 400, n);
    chk("R7 full interval after collision", n, 256 + GAP);

    // R2: modes 1..3
    for (int md = 1; md < 4; md++) begin
      unlock();
      wr(1'b0, cw(md, 0, 0, 1, 0, 0));
      wait_bit(3, 140000, n);
      chk($sformatf("R2 mode%0d warn edge", md), n, interval(md));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule